// File: doc/BRIEF.md
# Folded Triangle Envelope Generator

This block produces a slow, non-negative triangular envelope that a downstream stage uses as an amplitude coefficient. A phase accumulator of `PHASE_W` bits (1024 steps by default) advances by a small frequency word once per tick. The default tick rate is 40 Hz. The envelope frequency is therefore `step * f_tick / 2^PHASE_W`.

The upper `ENV_W` bits of the phase form a raw ramp. The lower half of that ramp passes through unchanged. The upper half is folded back down by a two's-complement negation taken in `ENV_W` bits. Over one cycle the output rises 0..8 and falls 7..1, with no lookup table. The result is registered and held between ticks. The tick source and the multiplier that consumes the envelope sit outside this block.

Top module: `tri_env_gen`

## Requirements
- R1: While `rst_n` is low, the phase and `env` are cleared to 0. This holds even if `tick` is high in the same cycle. After release, the first tick starts from phase 0.
- R2: On each clock edge with `tick` high, the phase becomes `(phase + step) mod 1024`. The 10-bit accumulator wraps silently.
- R3: On a tick, the raw value is bits 9..6 of the updated phase (phase divided by 64). A raw value from 0 to 7 is driven on `env` unchanged.
- R4: A raw value from 8 to 15 is replaced by its bitwise inverse plus one, taken in 4 bits (16 - raw). So 8 gives 8 and 15 gives 1.
- R5: On edges where `tick` is low, `env` holds its value. Changes of `step` have no effect until the next tick.
- R6: `env` never exceeds 8. From one tick to the next it changes by at most 1.
- R7: `env` reflects a tick one register stage later, in the cycle after the edge at which `tick` was high. `step` is sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable that advances the phase |
| step | input | 4 | Phase increment per tick |
| env | output | 4 | Folded triangle envelope, 0..8 |

## Verification
Two things can land on the same tick: the accumulator wrapping past 1023 and the fold boundary, where the raw value moves from 15 to 0. In that case the output must fall from 1 to 0 rather than jump. Sweeps with large step values push wraps through this boundary many times. A full-cycle run with step 1 passes every raw value, including the 7 to 8 and 8 to 9 turn points. Reset is also asserted together with a tick, to confirm that reset wins. Every tick result is compared against a phase model kept in the bench.

// File: rtl/tri_env_pkg.sv
package tri_env_pkg;
   typedef enum logic {
      FOLD_NEGATE   = 1'b0,
      FOLD_SUBTRACT = 1'b1
   } fold_style_e;
endpackage

// File: rtl/tri_env_phase.sv
module tri_env_phase #(
   parameter int PHASE_W = 10,
   parameter int FREQ_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [FREQ_W-1:0]  step,
   output logic [PHASE_W-1:0] phase_q,
   output logic [PHASE_W-1:0] phase_nx
);
   localparam int PAD_W = PHASE_W - FREQ_W;

   generate
      if (FREQ_W > PHASE_W) begin : g_bad_width
         $error("tri_env_phase: FREQ_W must not exceed PHASE_W");
      end
   endgenerate

   logic [PHASE_W-1:0] step_ext;

   generate
      if (PAD_W > 0) begin : g_pad
         assign step_ext = {{PAD_W{1'b0}}, step};
      end else begin : g_nopad
         assign step_ext = step;
      end
   endgenerate

   assign phase_nx = phase_q + step_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    phase_q <= '0;
      else if (tick) phase_q <= phase_nx;
   end

   // R2: advance by the sampled step, modulo 2^PHASE_W
   p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> phase_q == PHASE_W'($past(phase_q) + PHASE_W'($past(step))));

   // R5: no tick, no movement
   p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(phase_q));
endmodule

// File: rtl/tri_env_fold.sv
module tri_env_fold
   import tri_env_pkg::*;
#(
   parameter int          IN_W  = 4,
   parameter fold_style_e STYLE = FOLD_NEGATE
) (
   input  logic [IN_W-1:0] raw,
   output logic [IN_W-1:0] folded
);
   localparam int           HALF_BIT = IN_W - 1;
   localparam logic [IN_W:0] FULL    = (IN_W+1)'(1) << IN_W;

   generate
      if (IN_W < 2) begin : g_bad_width
         $error("tri_env_fold: IN_W must be at least 2");
      end
   endgenerate

   logic [IN_W-1:0] down;

   generate
      if (STYLE == FOLD_NEGATE) begin : g_negate
         assign down = ~raw + IN_W'(1);
      end else begin : g_subtract
         logic [IN_W:0] diff;
         assign diff = FULL - {1'b0, raw};
         assign down = diff[IN_W-1:0];
      end
   endgenerate

   always_comb begin
      if (raw[HALF_BIT]) folded = down;
      else               folded = raw;
   end

   // R3: lower half passes through
   always_comb begin
      if (!raw[HALF_BIT]) a_low_pass_r3: assert (folded == raw);
   end

   // R4: upper half maps to a non-zero value no larger than half scale
   always_comb begin
      if (raw[HALF_BIT])
         a_high_fold_r4: assert (folded != '0 && folded <= (IN_W'(1) << HALF_BIT));
   end
endmodule

// File: rtl/tri_env_gen.sv
module tri_env_gen
   import tri_env_pkg::*;
#(
   parameter int          PHASE_W    = 10,
   parameter int          FREQ_W     = 4,
   parameter int          ENV_W      = 4,
   parameter fold_style_e FOLD_STYLE = FOLD_NEGATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [FREQ_W-1:0] step,
   output logic [ENV_W-1:0]  env
);
   localparam int RAW_LO  = PHASE_W - ENV_W;
   localparam int PEAK    = 1 << (ENV_W - 1);
   localparam int MAX_INC = (1 << FREQ_W) - 1;

   generate
      if (ENV_W > PHASE_W) begin : g_bad_env
         $error("tri_env_gen: ENV_W must not exceed PHASE_W");
      end
      if (MAX_INC > (1 << RAW_LO)) begin : g_bad_step
         $error("tri_env_gen: step range too large for a unit-slope envelope");
      end
   endgenerate

   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W-1:0] phase_nx;
   logic [ENV_W-1:0]   raw_nx;
   logic [ENV_W-1:0]   fold_nx;

   tri_env_phase #(
      .PHASE_W (PHASE_W),
      .FREQ_W  (FREQ_W)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .step     (step),
      .phase_q  (phase_q),
      .phase_nx (phase_nx)
   );

   assign raw_nx = phase_nx[PHASE_W-1:RAW_LO];

   tri_env_fold #(
      .IN_W  (ENV_W),
      .STYLE (FOLD_STYLE)
   ) u_fold (
      .raw    (raw_nx),
      .folded (fold_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    env <= '0;
      else if (tick) env <= fold_nx;
   end

   // R5: output held without a tick
   p_env_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(env));

   // R6: range bounded by the peak
   p_env_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(env) <= PEAK);

   // R6: unit slope between consecutive ticks
   p_env_slope_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (int'(env) - int'($past(env)) <= 1) && (int'($past(env)) - int'(env) <= 1));

   // R3 / R7: rising half of the phase shows up directly one stage later
   p_env_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !phase_q[PHASE_W-1] -> env == phase_q[PHASE_W-1:RAW_LO]);
endmodule

// File: tb/tri_env_gen_bench.sv
module tri_env_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [3:0] step = 4'd0;
   logic [3:0] env;

   int total = 0;
   int bad   = 0;
   int model_phase = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tri_env_gen u_tri_env_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .step  (step),
      .env   (env)
   );

   function automatic int fold_ref(input int ph);
      int r;
      r = (ph / 64) % 16;
      return (r < 8) ? r : 16 - r;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: env actual=%0d expected=%0d (phase model %0d)", req, act, exp, model_phase);
      end
   endtask

   // R2 R3 R4 R7: one tick, checked in the cycle after the edge
   task automatic do_tick(input int s, input string req);
      int prev;
      prev = fold_ref(model_phase);
      @(negedge clk);
      tick = 1'b1;
      step = 4'(s);
      @(negedge clk);
      tick = 1'b0;
      model_phase = (model_phase + s) % 1024;
      check(req, int'(env), fold_ref(model_phase));
      if (int'(env) > 8 || int'(env) - prev > 1 || prev - int'(env) > 1) begin
         total++;
         bad++;
         $display("FAIL R6: env actual=%0d expected within 1 of %0d and <=8", env, prev);
      end
   endtask

   // R5: idle cycle with a scrambled step
   task automatic idle(input int s);
      int held;
      held = int'(env);
      @(negedge clk);
      step = 4'(s);
      @(negedge clk);
      check("R5", int'(env), held);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", int'(env), 0);
      rst_n = 1'b1;
      idle(9);

      // Full cycle with step 1: every raw value, both turn points, one wrap
      for (int k = 0; k < 1030; k++) do_tick(1, (k % 64 == 63) ? "R4" : "R3");

      // Sweep all step values, with irregular gaps
      for (int s = 0; s < 16; s++) begin
         for (int k = 0; k < 90; k++) begin
            do_tick(s, "R2");
            if (k % 7 == 3) idle((s + k) % 16);
         end
      end

      // Reset asserted together with a tick: reset wins
      @(negedge clk);
      tick = 1'b1;
      step = 4'd15;
      rst_n = 1'b0;
      @(negedge clk);
      tick = 1'b0;
      check("R1", int'(env), 0);
      rst_n = 1'b1;
      model_phase = 0;

      // After reset the phase restarts from 0
      for (int k = 0; k < 5; k++) do_tick(13, "R1");
      check("R1", int'(env), fold_ref(65));

      // Exact fold points: 8 at phase 512, 1 at phase 960
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_phase = 0;
      for (int k = 0; k < 32; k++) do_tick(16 - 0 - 1, "R3");
      while (model_phase < 512) do_tick(1, "R4");
      check("R4", int'(env), 8);
      while (model_phase < 960) do_tick(15, "R4");
      if (model_phase / 64 == 15) check("R4", int'(env), 1);

      done = 1'b1;
   end

   initial begin
      int cycles;
      cycles = 0;
      while (!done && cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule